// File: doc/BRIEF.md
# In-Order Issue Scoreboard

This block sits at the issue stage of an in-order pipeline with four functional units: integer/memory, add, multiply and divide. Every cycle it looks at the decoded instruction waiting to issue and decides whether it may go. It grants the instruction, names the unit it goes to, or raises a stall. To make that decision it keeps two pieces of state.

- A write-pending vector holds one bit per architectural register.
- A writeback reservation shift register holds one bit per future cycle, and marks the cycles in which a result with a destination will reach writeback.

Operands are latched when an instruction issues and issue is in order, so source registers of operations already in flight are never tracked. A later write to a register that an in-flight operation reads needs no check.

Each unit's pipeline is modelled as a row of stages. Every stage carries a valid bit, a write-enable and a destination tag. Each unit presents its last stage on a completion port. A unit with a latency of more than one cycle is unpipelined: it reports busy while an operation sits in any stage but its last. The writeback stage, outside this block, returns register numbers on the writeback input. Those numbers clear the pending bits.

Top module: `in_order_scoreboard`

## Requirements
- R1: A unit with latency L accepts a new operation no sooner than L cycles after its previous grant. While it is occupied, an instruction of that class is stalled. The integer and add units have a latency of 1 and accept an operation every cycle.
- R2: An instruction is stalled while the pending bit of either of its source registers is set (read-after-write).
- R3: An instruction with `in_wen`=1 is stalled while the pending bit of its destination register is set (write-after-write).
- R4: An instruction with `in_wen`=0 skips the destination check and sets no pending bit. It also neither checks nor reserves a writeback slot. It still occupies its unit, and it appears on the completion port with write-enable 0.
- R5: A grant with `in_wen`=1 sets the destination's pending bit from the next cycle. A writeback clears its register's bit from the next cycle. When both name the same register in the same cycle, the set wins. When they name different registers, both take effect.
- R6: An operation granted in cycle t appears in cycle t+L on bit c of `done_vld`, with its write-enable and destination. The class code c is 0 for integer, 1 for add, 2 for multiply and 3 for divide. The latencies are 1, 1, 3 and 4. The destination of unit c occupies bits [5c+4:5c] of `done_dst`.
- R7: An instruction with `in_wen`=1 and latency L is stalled if another operation with a destination already completes in cycle t+L. At most one completing operation per cycle carries a write-enable.
- R8: When granted, `iss_unit` is one-hot with bit c set; otherwise it is 0. `iss_stall` is high exactly when `in_vld` is high and there is no grant. With `in_vld` low there is neither a grant nor a stall.
- R9: After reset no unit is busy, no register is pending, no writeback slot is reserved and no completion is reported.
- R10: A write to a register that an in-flight operation reads as a source is not stalled, because there is no write-after-read check.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | An instruction is waiting at issue |
| in_cls | input | 2 | Unit class: 0 integer, 1 add, 2 multiply, 3 divide |
| in_dst | input | 5 | Destination register |
| in_wen | input | 1 | The instruction writes its destination |
| in_src1 | input | 5 | First source register |
| in_src2 | input | 5 | Second source register |
| wb_vld | input | 1 | A writeback retires a register this cycle |
| wb_reg | input | 5 | Register retired by the writeback |
| iss_go | output | 1 | The instruction issues this cycle |
| iss_unit | output | 4 | One-hot unit select for the granted instruction |
| iss_stall | output | 1 | A valid instruction is held back |
| done_vld | output | 4 | Per-unit completion valid |
| done_wen | output | 4 | Per-unit completion write-enable |
| done_dst | output | 20 | Per-unit completion destination, 5 bits per unit |

## Verification
The checker assumes that the environment returns a writeback for a register no earlier than the cycle in which that register's result appears on the completion port. Under that assumption, every completing operation with a write-enable still finds its destination pending. The stimulus drives each writeback in exactly the completion cycle that the bench's own latency arithmetic predicts. The only exception is the priority test, which sends a writeback for a register that is not pending at all. That stray writeback cannot break the assumption, because the set takes priority over it.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int NUM_UNITS = 4;

    typedef enum logic [1:0] {
        UC_INT = 2'd0,
        UC_ADD = 2'd1,
        UC_MUL = 2'd2,
        UC_DIV = 2'd3
    } unit_cls_e;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sb_unit_pipe.sv
module sb_unit_pipe #(
    parameter int LAT = 1,
    parameter int RW  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic          ld_wen,
    input  logic [RW-1:0] ld_dst,
    output logic          busy,
    output logic          fin_vld,
    output logic          fin_wen,
    output logic [RW-1:0] fin_dst
);

    typedef struct packed {
        logic          vld;
        logic          wen;
        logic [RW-1:0] dst;
    } stage_t;

    typedef struct packed {
        stage_t [LAT-1:0] stg;
    } pipe_state_t;

    pipe_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0].vld = ld;
        st_d.stg[0].wen = ld & ld_wen;
        st_d.stg[0].dst = ld_dst;
        for (int i = 1; i < LAT; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (LAT > 1) begin : g_multi
            always_comb begin
                busy = 1'b0;
                for (int i = 0; i < LAT - 1; i++) begin
                    busy = busy | st_q.stg[i].vld;
                end
            end
        end else begin : g_single
            assign busy = 1'b0;
        end
    endgenerate

    assign fin_vld = st_q.stg[LAT-1].vld;
    assign fin_wen = st_q.stg[LAT-1].wen;
    assign fin_dst = st_q.stg[LAT-1].dst;

endmodule

// File: rtl/sb_wpend.sv
module sb_wpend #(
    parameter int NREG = 32,
    parameter int RW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [RW-1:0]   set_reg,
    input  logic            clr_en,
    input  logic [RW-1:0]   clr_reg,
    output logic [NREG-1:0] pend
);

    typedef struct packed {
        logic [NREG-1:0] bits;
    } wp_state_t;

    wp_state_t wp_d, wp_q;

    always_comb begin
        wp_d = wp_q;
        if (clr_en) wp_d.bits[clr_reg] = 1'b0;
        if (set_en) wp_d.bits[set_reg] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q <= '0;
        end else begin
            wp_q <= wp_d;
        end
    end

    assign pend = wp_q.bits;

endmodule

// File: rtl/sb_wb_resv.sv
module sb_wb_resv #(
    parameter int SLOTS = 5,
    parameter int LW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_en,
    input  logic [LW-1:0]    res_lat,
    output logic [SLOTS-1:0] slot
);

    typedef struct packed {
        logic [SLOTS-1:0] occ;
    } resv_state_t;

    resv_state_t rv_d, rv_q;

    always_comb begin
        rv_d = '0;
        for (int i = 0; i < SLOTS - 1; i++) begin
            rv_d.occ[i] = rv_q.occ[i+1];
        end
        if (res_en && (int'(res_lat) >= 1) && (int'(res_lat) <= SLOTS - 1)) begin
            rv_d.occ[int'(res_lat) - 1] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rv_q <= '0;
        end else begin
            rv_q <= rv_d;
        end
    end

    assign slot = rv_q.occ;

endmodule

// File: rtl/sb_issue_ctl.sv
module sb_issue_ctl
    import sb_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int RW    = 5,
    parameter int SLOTS = 5,
    parameter int LW    = 3
) (
    input  logic                 in_vld,
    input  logic [1:0]           in_cls,
    input  logic [RW-1:0]        in_dst,
    input  logic                 in_wen,
    input  logic [RW-1:0]        in_src1,
    input  logic [RW-1:0]        in_src2,
    input  logic [NUM_UNITS-1:0] unit_busy,
    input  logic [NREG-1:0]      pend,
    input  logic [SLOTS-1:0]     slot,
    input  logic [LW-1:0]        sel_lat,
    output logic                 go,
    output logic [NUM_UNITS-1:0] unit,
    output logic                 stall
);

    logic fu_ok, raw_ok, waw_ok, wb_ok, slot_taken;

    always_comb begin
        slot_taken = 1'b0;
        if (int'(sel_lat) < SLOTS) slot_taken = slot[sel_lat];
        fu_ok  = !unit_busy[in_cls];
        raw_ok = !pend[in_src1] && !pend[in_src2];
        waw_ok = !in_wen || !pend[in_dst];
        wb_ok  = !in_wen || !slot_taken;
        go     = in_vld && fu_ok && raw_ok && waw_ok && wb_ok;
        unit   = '0;
        if (go) unit[in_cls] = 1'b1;
        stall  = in_vld && !go;
    end

endmodule

// File: rtl/in_order_scoreboard.sv
module in_order_scoreboard
    import sb_pkg::*;
#(
    parameter int NREG    = 32,
    parameter int LAT_INT = 1,
    parameter int LAT_ADD = 1,
    parameter int LAT_MUL = 3,
    parameter int LAT_DIV = 4,
    parameter int RW      = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld,
    input  logic [1:0]              in_cls,
    input  logic [RW-1:0]           in_dst,
    input  logic                    in_wen,
    input  logic [RW-1:0]           in_src1,
    input  logic [RW-1:0]           in_src2,
    input  logic                    wb_vld,
    input  logic [RW-1:0]           wb_reg,
    output logic                    iss_go,
    output logic [NUM_UNITS-1:0]    iss_unit,
    output logic                    iss_stall,
    output logic [NUM_UNITS-1:0]    done_vld,
    output logic [NUM_UNITS-1:0]    done_wen,
    output logic [NUM_UNITS*RW-1:0] done_dst
);

    localparam int MAXL  = max_of4(LAT_INT, LAT_ADD, LAT_MUL, LAT_DIV);
    localparam int SLOTS = MAXL + 1;
    localparam int LW    = $clog2(SLOTS + 1);
    localparam int LATS [NUM_UNITS] = '{LAT_INT, LAT_ADD, LAT_MUL, LAT_DIV};

    logic [NUM_UNITS-1:0] unit_busy;
    logic [NREG-1:0]      wp_vec;
    logic [SLOTS-1:0]     wb_slot;
    logic [LW-1:0]        sel_lat;
    logic                 claim_wr;

    always_comb begin
        sel_lat = LW'(LATS[in_cls]);
    end

    assign claim_wr = iss_go && in_wen;

    sb_issue_ctl #(
        .NREG(NREG), .RW(RW), .SLOTS(SLOTS), .LW(LW)
    ) u_ctl (
        .in_vld   (in_vld),
        .in_cls   (in_cls),
        .in_dst   (in_dst),
        .in_wen   (in_wen),
        .in_src1  (in_src1),
        .in_src2  (in_src2),
        .unit_busy(unit_busy),
        .pend     (wp_vec),
        .slot     (wb_slot),
        .sel_lat  (sel_lat),
        .go       (iss_go),
        .unit     (iss_unit),
        .stall    (iss_stall)
    );

    sb_wpend #(.NREG(NREG), .RW(RW)) u_wp (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (claim_wr),
        .set_reg(in_dst),
        .clr_en (wb_vld),
        .clr_reg(wb_reg),
        .pend   (wp_vec)
    );

    sb_wb_resv #(.SLOTS(SLOTS), .LW(LW)) u_resv (
        .clk    (clk),
        .rst_n  (rst_n),
        .res_en (claim_wr),
        .res_lat(sel_lat),
        .slot   (wb_slot)
    );

    generate
        for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
            sb_unit_pipe #(.LAT(LATS[u]), .RW(RW)) u_pipe (
                .clk    (clk),
                .rst_n  (rst_n),
                .ld     (iss_unit[u]),
                .ld_wen (in_wen),
                .ld_dst (in_dst),
                .busy   (unit_busy[u]),
                .fin_vld(done_vld[u]),
                .fin_wen(done_wen[u]),
                .fin_dst(done_dst[u*RW +: RW])
            );
        end
    endgenerate

endmodule

// File: rtl/sb_checker.sv
module sb_checker
    import sb_pkg::*;
#(
    parameter int NREG = 32,
    parameter int RW   = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [1:0]              in_cls,
    input logic [RW-1:0]           in_dst,
    input logic                    in_wen,
    input logic [RW-1:0]           in_src1,
    input logic [RW-1:0]           in_src2,
    input logic                    iss_go,
    input logic [NUM_UNITS-1:0]    iss_unit,
    input logic [NUM_UNITS-1:0]    done_vld,
    input logic [NUM_UNITS-1:0]    done_wen,
    input logic [NUM_UNITS*RW-1:0] done_dst,
    input logic [NUM_UNITS-1:0]    unit_busy,
    input logic [NREG-1:0]         wp_vec
);

    // R1: a granted class never targets an occupied unit
    a_r1_unit_free: assert property (@(posedge clk) disable iff (!rst_n)
        iss_go |-> !unit_busy[in_cls]);

    // R1: a multi-cycle unit is occupied right after a grant
    a_r1_mul_occupied: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_go && in_cls == UC_MUL) |=> unit_busy[UC_MUL]);

    // R2
    a_r2_no_raw: assert property (@(posedge clk) disable iff (!rst_n)
        iss_go |-> (!wp_vec[in_src1] && !wp_vec[in_src2]));

    // R3
    a_r3_no_waw: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_go && in_wen) |-> !wp_vec[in_dst]);

    // R4
    a_r4_nodst_no_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_go && !in_wen && !wp_vec[in_dst]) |=> !wp_vec[$past(in_dst)]);

    // R5
    a_r5_mark_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_go && in_wen) |=> wp_vec[$past(in_dst)]);

    // R7
    a_r7_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(done_vld & done_wen) <= 1);

    // R8
    a_r8_unit_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(iss_unit));

    // R6: a result with a write-enable still finds its register pending
    generate
        for (genvar u = 0; u < NUM_UNITS; u++) begin : g_res
            a_r6_result_pending: assert property (@(posedge clk) disable iff (!rst_n)
                (done_vld[u] && done_wen[u]) |-> wp_vec[done_dst[u*RW +: RW]]);
        end
    endgenerate

endmodule

bind in_order_scoreboard sb_checker #(.NREG(NREG), .RW(RW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_cls   (in_cls),
    .in_dst   (in_dst),
    .in_wen   (in_wen),
    .in_src1  (in_src1),
    .in_src2  (in_src2),
    .iss_go   (iss_go),
    .iss_unit (iss_unit),
    .done_vld (done_vld),
    .done_wen (done_wen),
    .done_dst (done_dst),
    .unit_busy(unit_busy),
    .wp_vec   (wp_vec)
);

// File: tb/tb_in_order_scoreboard.sv
module tb_in_order_scoreboard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [1:0]  in_cls = '0;
    logic [4:0]  in_dst = '0;
    logic        in_wen = 1'b0;
    logic [4:0]  in_src1 = '0;
    logic [4:0]  in_src2 = '0;
    logic        wb_vld = 1'b0;
    logic [4:0]  wb_reg = '0;
    logic        iss_go;
    logic [3:0]  iss_unit;
    logic        iss_stall;
    logic [3:0]  done_vld;
    logic [3:0]  done_wen;
    logic [19:0] done_dst;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    in_order_scoreboard dut (
        .clk(clk), .rst_n(rst_n),
        .in_vld(in_vld), .in_cls(in_cls), .in_dst(in_dst), .in_wen(in_wen),
        .in_src1(in_src1), .in_src2(in_src2),
        .wb_vld(wb_vld), .wb_reg(wb_reg),
        .iss_go(iss_go), .iss_unit(iss_unit), .iss_stall(iss_stall),
        .done_vld(done_vld), .done_wen(done_wen), .done_dst(done_dst)
    );

    typedef struct packed {
        logic       vld;
        logic [1:0] cls;
        logic [4:0] dst;
        logic       wen;
        logic [4:0] s1;
        logic [4:0] s2;
        logic       wbv;
        logic [4:0] wbr;
        logic       go;
        logic [3:0] req;
    } vec_t;

    // cls: 0 int(1), 1 add(1), 2 mul(3), 3 div(4)
    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd2, 5'd1,  1'b1, 5'd2, 5'd3, 1'b0, 5'd0,  1'b1, 4'd9},  // c0  R9 first grant after reset
        '{1'b1, 2'd2, 5'd4,  1'b1, 5'd2, 5'd3, 1'b0, 5'd0,  1'b0, 4'd1},  // c1  R1 mul occupied
        '{1'b1, 2'd1, 5'd5,  1'b1, 5'd1, 5'd2, 1'b0, 5'd0,  1'b0, 4'd2},  // c2  R2 r1 pending
        '{1'b1, 2'd0, 5'd6,  1'b1, 5'd2, 5'd3, 1'b1, 5'd1,  1'b1, 4'd5},  // c3  R5 set r6, clear r1
        '{1'b1, 2'd1, 5'd7,  1'b1, 5'd1, 5'd6, 1'b1, 5'd6,  1'b0, 4'd2},  // c4  R2 r6 pending
        '{1'b1, 2'd1, 5'd7,  1'b1, 5'd1, 5'd6, 1'b0, 5'd0,  1'b1, 4'd5},  // c5  R5 both cleared
        '{1'b1, 2'd3, 5'd8,  1'b1, 5'd2, 5'd3, 1'b1, 5'd7,  1'b1, 4'd1},  // c6  R1 div free
        '{1'b1, 2'd2, 5'd9,  1'b1, 5'd2, 5'd3, 1'b0, 5'd0,  1'b0, 4'd7},  // c7  R7 collides with div
        '{1'b1, 2'd2, 5'd9,  1'b1, 5'd2, 5'd3, 1'b0, 5'd0,  1'b1, 4'd7},  // c8  R7 free slot
        '{1'b1, 2'd0, 5'd8,  1'b1, 5'd2, 5'd3, 1'b0, 5'd0,  1'b0, 4'd3},  // c9  R3 r8 pending
        '{1'b1, 2'd0, 5'd8,  1'b0, 5'd2, 5'd3, 1'b1, 5'd8,  1'b1, 4'd4},  // c10 R4 no destination
        '{1'b1, 2'd0, 5'd9,  1'b1, 5'd2, 5'd3, 1'b1, 5'd9,  1'b0, 4'd3},  // c11 R3 r9 pending
        '{1'b1, 2'd3, 5'd2,  1'b1, 5'd8, 5'd9, 1'b0, 5'd0,  1'b1, 4'd2},  // c12 R2 sources free
        '{1'b1, 2'd0, 5'd9,  1'b1, 5'd3, 5'd4, 1'b0, 5'd0,  1'b1, 4'd10}, // c13 R10 write r9 read by div
        '{1'b0, 2'd0, 5'd0,  1'b0, 5'd0, 5'd0, 1'b1, 5'd9,  1'b0, 4'd8},  // c14 R8 idle
        '{1'b1, 2'd1, 5'd11, 1'b1, 5'd2, 5'd3, 1'b0, 5'd0,  1'b0, 4'd2},  // c15 R2 r2 pending
        '{1'b1, 2'd1, 5'd11, 1'b1, 5'd3, 5'd4, 1'b1, 5'd2,  1'b1, 4'd2},  // c16 R2 granted
        '{1'b0, 2'd0, 5'd0,  1'b0, 5'd0, 5'd0, 1'b1, 5'd11, 1'b0, 4'd8}   // c17 R8 idle
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [1:0] c, input logic [4:0] d, input logic w,
                        input logic [4:0] a, input logic [4:0] b,
                        input logic wv, input logic [4:0] wr);
        @(negedge clk);
        in_vld = v; in_cls = c; in_dst = d; in_wen = w;
        in_src1 = a; in_src2 = b; wb_vld = wv; wb_reg = wr;
        #1;
    endtask

    task automatic idle(input logic wv, input logic [4:0] wr);
        step(1'b0, 2'd0, 5'd0, 1'b0, 5'd0, 5'd0, wv, wr);
    endtask

    task automatic expect_go(input string req, input logic g, input logic [1:0] c, input logic v);
        check({req, " go"}, 32'(iss_go), 32'(g));
        check({req, " unit"}, 32'(iss_unit), g ? 32'(4'b1 << c) : 32'd0);
        check({req, " stall"}, 32'(iss_stall), 32'(v & ~g));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9: reset state
        check("R9 done_vld", 32'(done_vld), 32'd0);
        check("R9 iss_stall", 32'(iss_stall), 32'd0);
        check("R9 iss_go", 32'(iss_go), 32'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i].vld, VEC[i].cls, VEC[i].dst, VEC[i].wen,
                 VEC[i].s1, VEC[i].s2, VEC[i].wbv, VEC[i].wbr);
            expect_go($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].go, VEC[i].cls, VEC[i].vld);
        end

        // R6 / R1: multiply timing and completion port
        step(1'b1, 2'd2, 5'd12, 1'b1, 5'd2, 5'd3, 1'b0, 5'd0);
        expect_go("R6 mul issue", 1'b1, 2'd2, 1'b1);
        step(1'b1, 2'd2, 5'd13, 1'b1, 5'd2, 5'd3, 1'b0, 5'd0);
        expect_go("R1 mul busy t+1", 1'b0, 2'd2, 1'b1);
        check("R6 no done t+1", 32'(done_vld), 32'd0);
        step(1'b1, 2'd2, 5'd13, 1'b1, 5'd2, 5'd3, 1'b0, 5'd0);
        expect_go("R1 mul busy t+2", 1'b0, 2'd2, 1'b1);
        check("R6 no done t+2", 32'(done_vld), 32'd0);
        step(1'b1, 2'd2, 5'd13, 1'b1, 5'd2, 5'd3, 1'b1, 5'd12);
        expect_go("R1 mul free t+3", 1'b1, 2'd2, 1'b1);
        check("R6 mul done t+3", 32'(done_vld), 32'h4);
        check("R6 mul wen", 32'(done_wen[2]), 32'd1);
        check("R6 mul dst", 32'(done_dst[14:10]), 32'd12);
        idle(1'b0, 5'd0);
        idle(1'b0, 5'd0);
        idle(1'b1, 5'd13);
        check("R6 second mul done", 32'(done_vld), 32'h4);
        check("R6 second mul dst", 32'(done_dst[14:10]), 32'd13);

        // R6 integer latency 1, R4 divide without destination
        step(1'b1, 2'd0, 5'd14, 1'b1, 5'd0, 5'd1, 1'b0, 5'd0);
        expect_go("R6 int issue", 1'b1, 2'd0, 1'b1);
        step(1'b1, 2'd3, 5'd3, 1'b0, 5'd0, 5'd0, 1'b1, 5'd14);
        expect_go("R4 div no dst", 1'b1, 2'd3, 1'b1);
        check("R6 int done", 32'(done_vld), 32'h1);
        check("R6 int dst", 32'(done_dst[4:0]), 32'd14);
        idle(1'b0, 5'd0);
        idle(1'b0, 5'd0);
        idle(1'b0, 5'd0);
        check("R6 div not yet", 32'(done_vld), 32'd0);
        idle(1'b0, 5'd0);
        check("R6 div done", 32'(done_vld), 32'h8);
        check("R4 div wen low", 32'(done_wen[3]), 32'd0);

        // R5: set and clear of the same register, set wins
        step(1'b1, 2'd0, 5'd3, 1'b1, 5'd0, 5'd1, 1'b1, 5'd3);
        expect_go("R5 same-reg issue", 1'b1, 2'd0, 1'b1);
        step(1'b1, 2'd1, 5'd20, 1'b1, 5'd3, 5'd0, 1'b1, 5'd3);
        expect_go("R5 set wins", 1'b0, 2'd1, 1'b1);
        step(1'b1, 2'd1, 5'd20, 1'b1, 5'd3, 5'd0, 1'b0, 5'd0);
        expect_go("R5 later clear", 1'b1, 2'd1, 1'b1);
        idle(1'b1, 5'd20);

        // R5: set and clear of different registers, both take effect
        step(1'b1, 2'd0, 5'd4, 1'b1, 5'd0, 5'd1, 1'b0, 5'd0);
        expect_go("R5 pend r4", 1'b1, 2'd0, 1'b1);
        step(1'b1, 2'd0, 5'd5, 1'b1, 5'd0, 5'd1, 1'b1, 5'd4);
        expect_go("R5 pend r5 clear r4", 1'b1, 2'd0, 1'b1);
        step(1'b1, 2'd1, 5'd21, 1'b1, 5'd5, 5'd0, 1'b1, 5'd5);
        expect_go("R5 r5 set kept", 1'b0, 2'd1, 1'b1);
        step(1'b1, 2'd1, 5'd21, 1'b1, 5'd4, 5'd5, 1'b0, 5'd0);
        expect_go("R5 r4 clear kept", 1'b1, 2'd1, 1'b1);
        idle(1'b1, 5'd21);
        idle(1'b0, 5'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule